// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two independent interval timers that count core clock cycles. Each timer is a pair of 16-bit down-counters in cascade. The first stage is a prescaler and the second is a divider. When both stages reach zero together, the timer raises a one-cycle expiry pulse. It then reloads both stages from its programmed values and keeps counting with no software action, so the counters never stop. The period of each timer in clock cycles is (prescaler+1)*(divider+1).

Software programs the timers over a 16-bit register bus with byte enables. Each timer has two write-only reload registers. Writing either register of a timer, whole or one byte, restarts that timer from its full period. The live value of every stage can be read at its own offset, which is separate from the write offsets. Reading has no side effects. Masking and routing of the expiry pulses belong to an interrupt controller outside this block.

Top module: `dual_interval_timer`

## Requirements
- R1: While reset is high and after its release, all four reload values are 0xFFFF, every stage count is 0xFFFF and both expiry outputs are low.
- R2: Writes decode byte offsets 0x0 (timer 0 prescaler), 0x2 (timer 0 divider), 0x4 (timer 1 prescaler) and 0x6 (timer 1 divider). Offset bit 0 is ignored.
- R3: `bus_rdata` is combinational. It shows the live timer 0 prescaler count at 0x36/0x37, the timer 0 divider count at 0x38/0x39, the timer 1 prescaler count at 0x3A/0x3B and the timer 1 divider count at 0x3C/0x3D. Every other offset reads 0. Reading changes nothing.
- R4: A timer with reload values P and D raises its `expire` bit for exactly one cycle every (P+1)*(D+1) cycles. The bit goes high in the cycle after the one in which both of its stage counts read zero.
- R5: In each cycle where no write hits it, a timer does one of three things. A non-zero prescaler count decrements. A zero prescaler count with a non-zero divider count reloads the prescaler and decrements the divider. With both counts zero, both stages reload.
- R6: A write to a timer loads both of its stages with the new reload values in the next cycle. The other timer is not disturbed.
- R7: `bus_be[0]` selects bits 7:0 and `bus_be[1]` selects bits 15:8. A write with one enable updates only that byte of the reload value and still restarts the timer.
- R8: When a write to a timer falls in the cycle where its counts are both zero, the restart wins and no expiry pulse is produced.
- R9: With both reload values 0, the timer's `expire` bit stays high on every cycle.
- R10: Writes to any offset outside 0x0–0x7, and writes with both byte enables low, change no reload value and restart nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, counted by both timers |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_be | input | 2 | Byte enables, bit 0 = low byte |
| bus_addr | input | 6 | Byte offset for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Live stage count at the addressed readback offset, else 0 |
| expire | output | 2 | One-cycle expiry pulse per timer, bit n for timer n |

## Verification
A reload write and a natural expiry can land in the same cycle. To provoke this, the bench restarts a timer with a period of 12 and then issues a second write timed to the exact cycle in which both stage counts are zero. The judgement is that the expiry bit stays low at that point and that the next pulse comes a full period after the second write. A behavioural model of the remaining cycles in each period is compared with the expiry bits and the readback data on every clock, including during a random phase in which writes, byte enables and readback addresses mix freely.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int DATA_W = 16;
    localparam int BYTES  = DATA_W / 8;
    localparam int ADDR_W = 6;
    localparam int N_TMR  = 2;
    localparam logic [ADDR_W-1:0] LIVE_BASE = 6'h36;
    localparam logic [ADDR_W-1:0] LIVE_LAST = LIVE_BASE + 6'd7;

    // one timer's pair of stages (reload values or live counts)
    typedef struct packed {
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] pre;
    } pair_t;

    // decoded register select: stg 0 = prescaler, 1 = divider
    typedef struct packed {
        logic hit;
        logic tmr;
        logic stg;
    } sel_t;

    function automatic sel_t wr_decode(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.hit = (a[ADDR_W-1:3] == '0);
        s.tmr = a[2];
        s.stg = a[1];
        return s;
    endfunction

    function automatic sel_t rd_decode(input logic [ADDR_W-1:0] a);
        sel_t s;
        logic [ADDR_W-1:0] off;
        off   = a - LIVE_BASE;
        s.hit = (a >= LIVE_BASE) && (a <= LIVE_LAST);
        s.tmr = off[2];
        s.stg = off[1];
        return s;
    endfunction
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
    import dtmr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [BYTES-1:0]         bus_be,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output pair_t [N_TMR-1:0]        rld_q,
    output pair_t [N_TMR-1:0]        rld_d,
    output logic  [N_TMR-1:0]        restart
);
    sel_t ws;

    always_comb begin
        ws      = wr_decode(bus_addr);
        rld_d   = rld_q;
        restart = '0;
        if (bus_wr && (|bus_be) && ws.hit) begin
            restart[ws.tmr] = 1'b1;
            for (int b = 0; b < BYTES; b++) begin
                if (bus_be[b]) begin
                    if (ws.stg)
                        rld_d[ws.tmr].div[b*8 +: 8] = bus_wdata[b*8 +: 8];
                    else
                        rld_d[ws.tmr].pre[b*8 +: 8] = bus_wdata[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rld_q <= '1;
        else     rld_q <= rld_d;
    end
endmodule

// File: rtl/dtmr_chain.sv
module dtmr_chain
    import dtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  pair_t rld_q,
    input  pair_t rld_d,
    output pair_t live,
    output logic  expire
);
    logic at_zero;
    assign at_zero = (live.pre == '0) && (live.div == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= '1;
            expire <= 1'b0;
        end else if (restart) begin
            live   <= rld_d;
            expire <= 1'b0;
        end else begin
            expire <= at_zero;
            if (at_zero) begin
                live <= rld_q;
            end else if (live.pre == '0) begin
                live.pre <= rld_q.pre;
                live.div <= live.div - 1'b1;
            end else begin
                live.pre <= live.pre - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
    import dtmr_pkg::*;
(
    input  logic [ADDR_W-1:0]  bus_addr,
    input  pair_t [N_TMR-1:0]  live,
    output logic [DATA_W-1:0]  bus_rdata
);
    sel_t rs;

    always_comb begin
        rs = rd_decode(bus_addr);
        if (!rs.hit)     bus_rdata = '0;
        else if (rs.stg) bus_rdata = live[rs.tmr].div;
        else             bus_rdata = live[rs.tmr].pre;
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [5:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [1:0]        expire
);
    pair_t [N_TMR-1:0] rld_q;
    pair_t [N_TMR-1:0] rld_d;
    pair_t [N_TMR-1:0] live;
    logic  [N_TMR-1:0] restart;

    dtmr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rld_q     (rld_q),
        .rld_d     (rld_d),
        .restart   (restart)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        dtmr_chain u_chain (
            .clk     (clk),
            .rst     (rst),
            .restart (restart[t]),
            .rld_q   (rld_q[t]),
            .rld_d   (rld_d[t]),
            .live    (live[t]),
            .expire  (expire[t])
        );
    end

    dtmr_rdmux u_rdmux (
        .bus_addr  (bus_addr),
        .live      (live),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [5:0]        bus_addr,
    input  pair_t [N_TMR-1:0] live,
    input  pair_t [N_TMR-1:0] rld,
    input  logic [1:0]        expire
);
    logic [N_TMR-1:0] hit;

    for (genvar t = 0; t < N_TMR; t++) begin : g_chk
        assign hit[t] = bus_wr && (|bus_be) && (bus_addr[5:3] == 3'b000) && (bus_addr[2] == t[0]);

        // R1: reset state
        p_reset_state_r1: assert property (@(posedge clk)
            rst |=> (live[t] == '1 && !expire[t]));

        // R4: pulse follows a zero state when no write intervenes
        p_expire_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (!hit[t] && live[t].pre == '0 && live[t].div == '0) |=> expire[t]);

        // R4: no pulse without a preceding zero state
        p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
            expire[t] |-> ($past(live[t].pre) == '0 && $past(live[t].div) == '0));

        // R5: prescaler step
        p_pre_step_r5: assert property (@(posedge clk) disable iff (rst)
            (!hit[t] && live[t].pre != '0) |=>
            (live[t].pre == $past(live[t].pre) - 1'b1 && $stable(live[t].div)));

        // R5: divider step with prescaler reload
        p_div_step_r5: assert property (@(posedge clk) disable iff (rst)
            (!hit[t] && live[t].pre == '0 && live[t].div != '0) |=>
            (live[t].pre == rld[t].pre && live[t].div == $past(live[t].div) - 1'b1));

        // R6 / R8: a write restarts the timer and suppresses the pulse
        p_restart_r6: assert property (@(posedge clk) disable iff (rst)
            hit[t] |=> (live[t] == rld[t] && !expire[t]));
    end
endmodule

bind dual_interval_timer dtmr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_be   (bus_be),
    .bus_addr (bus_addr),
    .live     (live),
    .rld      (rld_q),
    .expire   (expire)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [5:0]  bus_addr = 6'h36;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [1:0]  expire;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_interval_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .expire(expire)
    );

    // ---------------- behavioural reference: cycles left in each period
    longint rl_pre [2];
    longint rl_div [2];
    longint rem_m  [2];
    bit     exp_m  [2];

    function automatic longint full_len(int t);
        return (rl_pre[t] + 1) * (rl_div[t] + 1);
    endfunction

    always @(posedge clk) begin
        for (int t = 0; t < 2; t++) begin
            if (rst) begin
                rl_pre[t] = 16'hFFFF;
                rl_div[t] = 16'hFFFF;
                rem_m[t]  = full_len(t) - 1;
                exp_m[t]  = 1'b0;
            end else if (bus_wr && bus_be != 2'b00 && bus_addr < 6'd8 && bus_addr[2] == t[0]) begin
                longint v;
                v = bus_addr[1] ? rl_div[t] : rl_pre[t];
                if (bus_be[0]) v = (v & 64'hFF00) | longint'(bus_wdata[7:0]);
                if (bus_be[1]) v = (v & 64'h00FF) | (longint'(bus_wdata[15:8]) << 8);
                if (bus_addr[1]) rl_div[t] = v; else rl_pre[t] = v;
                rem_m[t] = full_len(t) - 1;
                exp_m[t] = 1'b0;
            end else if (rem_m[t] == 0) begin
                exp_m[t] = 1'b1;
                rem_m[t] = full_len(t) - 1;
            end else begin
                exp_m[t] = 1'b0;
                rem_m[t] = rem_m[t] - 1;
            end
        end
    end

    function automatic logic [15:0] exp_rdata(logic [5:0] a);
        int idx, t;
        if (a < 6'h36 || a > 6'h3D) return 16'h0;
        idx = (int'(a) - 'h36) >> 1;
        t = idx >> 1;
        if (idx & 1) return 16'(rem_m[t] / (rl_pre[t] + 1));
        return 16'(rem_m[t] % (rl_pre[t] + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // every clock: compare outputs with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 expire[0] vs model", 32'(expire[0]), 32'(exp_m[0]));
            check("R4 expire[1] vs model", 32'(expire[1]), 32'(exp_m[1]));
            check("R5 rdata vs model", 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
        end
    end

    // ---------------- stimulus helpers
    logic [5:0] rot = 6'h36;

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bus_addr = rot;
            rot = (rot == 6'h3C) ? 6'h36 : rot + 6'd2;
        end
    endtask

    // write, then leave bus_addr on a readback offset just before the next edge
    task automatic wr(logic [5:0] a, logic [1:0] be, logic [15:0] d, logic [5:0] rb);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_be = 2'b00; bus_addr = rb;
        #1;
    endtask

    int cnt;

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset values visible on readback
        @(negedge clk); #1 bus_addr = 6'h38;
        #1 check("R1 t0 divider count after reset", 32'(bus_rdata), 32'hFFFF);
        bus_addr = 6'h3C;
        #1 check("R1 t1 divider count after reset", 32'(bus_rdata), 32'hFFFF);
        check("R1 expire low after reset", 32'(expire), 32'h0);
        bus_addr = 6'h20;
        #1 check("R3 unmapped offset reads zero", 32'(bus_rdata), 32'h0);

        // R2/R6: program timer 0 with P=2, D=3 (period 12)
        wr(6'h00, 2'b11, 16'd2, 6'h36);
        wr(6'h02, 2'b11, 16'd3, 6'h38);
        check("R6 divider loaded on restart", 32'(bus_rdata), 32'd3);
        bus_addr = 6'h36;
        #1 check("R6 prescaler loaded on restart", 32'(bus_rdata), 32'd2);
        cnt = 0;
        for (int i = 0; i < 36; i++) begin
            @(negedge clk);
            if (expire[0]) cnt++;
        end
        check("R4 three pulses in 36 cycles", 32'(cnt), 32'd3);
        check("R6 timer 1 undisturbed, no pulse", 32'(expire[1]), 32'd0);

        // R8: write lands in the zero-state cycle
        wr(6'h00, 2'b11, 16'd2, 6'h36);
        idle(10);
        wr(6'h00, 2'b11, 16'd2, 6'h36);
        check("R8 restart suppresses pulse", 32'(expire[0]), 32'd0);
        cnt = 0;
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (expire[0]) cnt++;
        end
        check("R8 no pulse before full period", 32'(cnt), 32'd0);
        @(negedge clk);
        check("R8 pulse one full period later", 32'(expire[0]), 32'd1);

        // R10: ignored writes
        wr(6'h10, 2'b11, 16'd0, 6'h38);
        wr(6'h36, 2'b11, 16'd0, 6'h38);
        wr(6'h02, 2'b00, 16'd0, 6'h38);
        check("R10 ignored writes keep count", 32'(bus_rdata), 32'(exp_rdata(6'h38)));
        idle(20);

        // R7: byte writes on timer 1 prescaler
        wr(6'h04, 2'b01, 16'h1234, 6'h3A);
        check("R7 low byte only", 32'(bus_rdata), 32'hFF34);
        wr(6'h05, 2'b10, 16'hAB00, 6'h3A);
        check("R7 high byte only", 32'(bus_rdata), 32'hAB34);
        wr(6'h06, 2'b10, 16'h0000, 6'h3C);
        check("R7 divider high byte restart", 32'(bus_rdata), 32'h00FF);
        idle(30);

        // R9: period of one
        wr(6'h04, 2'b11, 16'd0, 6'h3A);
        wr(6'h06, 2'b11, 16'd0, 6'h3C);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (expire[1]) cnt++;
        end
        check("R9 pulse every cycle", 32'(cnt), 32'd20);

        // random mix, compared every clock by the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            if ($urandom_range(7) == 0) begin
                logic [5:0] choices [6] = '{6'h00, 6'h02, 6'h04, 6'h06, 6'h10, 6'h37};
                bus_wr    = 1'b1;
                bus_addr  = choices[$urandom_range(5)];
                bus_be    = 2'($urandom_range(3));
                bus_wdata = 16'($urandom_range(7));
            end else begin
                bus_wr   = 1'b0;
                bus_be   = 2'b00;
                bus_addr = 6'h34 + 6'($urandom_range(11));
            end
        end
        @(negedge clk); #1 bus_wr = 1'b0;
        idle(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule